// File: doc/BRIEF.md
# Warp Branch Divergence Mask Stack

This block tracks which threads of one 32-thread warp are active as the warp runs through branches. Each resolved branch brings a per-thread taken vector, the taken target PC and the fall-through PC. Taken bits belonging to inactive threads are discarded. If the remaining active threads all agree, the warp follows the chosen path and keeps its mask.

If the active threads disagree, the warp splits. The threads that did not take the branch continue at once at the fall-through PC under a reduced mask. The taken target, the taken-thread mask and the mask held before the branch are saved as one entry on a LIFO stack. Each stack entry is used by two reconvergence pulses. The first pulse switches the warp to the saved taken path. The second pulse restores the pre-branch mask at the reconvergence PC supplied with the pulse, and then removes the entry.

Nested divergence stacks up to a parameterised depth. A divergent branch that arrives while the stack is full is not saved, and it raises a sticky overflow flag.

Top module: `simt_diverge_stack`

## Requirements
- R1: After reset the active mask is all ones, the next PC equals the RESET_PC parameter (default 0), the overflow flag is 0 and the stack is empty.
- R2: On a branch where no active thread has its taken bit set, the next PC becomes the fall-through PC and the mask is unchanged. Taken bits of inactive threads have no effect.
- R3: On a branch where every active thread has its taken bit set, the next PC becomes the taken target and the mask is unchanged.
- R4: On a divergent branch, the mask becomes the active mask with the taken threads cleared and the next PC becomes the fall-through PC. The taken target, the taken-thread mask and the pre-branch mask are pushed as one entry.
- R5: The first reconverge pulse on the top entry sets the mask to that entry's taken-thread mask and the next PC to its target. The entry stays on the stack.
- R6: The second reconverge pulse on the top entry restores its pre-branch mask, sets the next PC to reconv_pc and pops the entry.
- R7: Nested divergences are handled in last-in first-out order, so the inner branch is resolved fully before the outer one resumes.
- R8: A divergent branch with DEPTH entries already stored sets a sticky overflow flag, still narrows the mask to the not-taken threads, and stores nothing. The stored entries are unaffected. Only reset clears the flag.
- R9: A reconverge pulse with an empty stack changes neither the PC nor the mask.
- R10: A cycle with neither a branch nor a reconverge pulse leaves the PC, the mask and the flag unchanged.
- R11: A branch and a reconverge pulse never arrive in the same cycle. This is a rule for the driver of the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | A branch is resolved this cycle |
| br_taken | input | LANES | Per-thread taken bits |
| br_target | input | PCW | Taken target PC |
| br_fallthru | input | PCW | Fall-through PC |
| reconv | input | 1 | Reconvergence pulse |
| reconv_pc | input | PCW | PC at which the threads rejoin on the second pulse |
| next_pc | output | PCW | PC the warp runs next |
| active_mask | output | LANES | Current per-thread active mask |
| overflow | output | 1 | Sticky flag: a divergent push was dropped |

## Verification
The two operations that can land in the same cycle are a divergence push and overflow detection. The bench provokes this by nesting eight single-thread divergences and then issuing a ninth. It checks that this last branch narrows the mask and raises the flag in the same cycle. The next two reconverge pulses must return the eighth entry's taken mask and then its pre-branch mask, which shows that nothing was stored for the ninth branch. A branch coinciding with a reconverge pulse is not permitted; the checker flags it, and the random phase never generates it.

// File: rtl/simt_diverge_stack.sv
module simt_diverge_stack #(
  parameter int LANES    = 32,
  parameter int PCW      = 32,
  parameter int DEPTH    = 8,
  parameter int RESET_PC = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             br_valid,
  input  logic [LANES-1:0] br_taken,
  input  logic [PCW-1:0]   br_target,
  input  logic [PCW-1:0]   br_fallthru,
  input  logic             reconv,
  input  logic [PCW-1:0]   reconv_pc,
  output logic [PCW-1:0]   next_pc,
  output logic [LANES-1:0] active_mask,
  output logic             overflow
);
  localparam int SPW = $clog2(DEPTH + 1);
  localparam int IW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PCW-1:0]   tgt_q  [DEPTH];
  logic [LANES-1:0] pend_q [DEPTH];
  logic [LANES-1:0] rest_q [DEPTH];
  logic [DEPTH-1:0] phase_q;
  logic [SPW-1:0]   sp_q;

  logic [LANES-1:0] eff;
  logic             none_taken, all_taken, diverge, full, empty, push, pop2;
  logic [IW-1:0]    wr_idx, top_idx;

  assign eff        = br_taken & active_mask;
  assign none_taken = (eff == '0);
  assign all_taken  = (eff == active_mask);
  assign diverge    = br_valid && !none_taken && !all_taken;
  assign full       = (sp_q == SPW'(DEPTH));
  assign empty      = (sp_q == '0);
  assign wr_idx     = IW'(sp_q);
  assign top_idx    = IW'(sp_q - 1'b1);
  assign push       = diverge && !full;
  assign pop2       = !br_valid && reconv && !empty && phase_q[top_idx];

  always_ff @(posedge clk) begin
    if (push) begin
      tgt_q[wr_idx]  <= br_target;
      pend_q[wr_idx] <= eff;
      rest_q[wr_idx] <= active_mask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      next_pc     <= PCW'(RESET_PC);
      active_mask <= '1;
      overflow    <= 1'b0;
      sp_q        <= '0;
      phase_q     <= '0;
    end else if (br_valid) begin
      if (none_taken) begin
        next_pc <= br_fallthru;
      end else if (all_taken) begin
        next_pc <= br_target;
      end else begin
        next_pc     <= br_fallthru;
        active_mask <= active_mask & ~br_taken;
        if (full) begin
          overflow <= 1'b1;
        end else begin
          phase_q[wr_idx] <= 1'b0;
          sp_q            <= sp_q + 1'b1;
        end
      end
    end else if (reconv && !empty) begin
      if (pop2) begin
        active_mask <= rest_q[top_idx];
        next_pc     <= reconv_pc;
        sp_q        <= sp_q - 1'b1;
      end else begin
        active_mask      <= pend_q[top_idx];
        next_pc          <= tgt_q[top_idx];
        phase_q[top_idx] <= 1'b1;
      end
    end
  end
endmodule

module simt_diverge_stack_chk #(
  parameter int LANES = 32,
  parameter int PCW   = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             br_valid,
  input logic [LANES-1:0] br_taken,
  input logic [PCW-1:0]   br_target,
  input logic [PCW-1:0]   br_fallthru,
  input logic             reconv,
  input logic [PCW-1:0]   reconv_pc,
  input logic [PCW-1:0]   next_pc,
  input logic [LANES-1:0] active_mask,
  input logic             overflow
);
  logic [LANES-1:0] eff;
  assign eff = br_taken & active_mask;

  // R2
  not_taken_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && eff == '0) |=> (active_mask == $past(active_mask) && next_pc == $past(br_fallthru)));
  // R3
  taken_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && eff != '0 && eff == active_mask) |=> (active_mask == $past(active_mask) && next_pc == $past(br_target)));
  // R4
  diverge_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && eff != '0 && eff != active_mask) |=> (active_mask == $past(active_mask & ~br_taken) && next_pc == $past(br_fallthru)));
  // R8
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!br_valid && !reconv) |=> ($stable(next_pc) && $stable(active_mask) && $stable(overflow)));
  // R11
  no_branch_reconv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(br_valid && reconv));
endmodule

bind simt_diverge_stack simt_diverge_stack_chk #(.LANES(LANES), .PCW(PCW)) chk_i (.*);

// File: tb/simt_diverge_stack_tb.sv
module simt_diverge_stack_tb_top;
  localparam int DEPTH = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic br_valid = 1'b0, reconv = 1'b0;
  logic [31:0] br_taken = '0, br_target = '0, br_fallthru = '0, reconv_pc = '0;
  logic [31:0] next_pc, active_mask;
  logic overflow;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  simt_diverge_stack #(.LANES(32), .PCW(32), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_taken(br_taken),
    .br_target(br_target), .br_fallthru(br_fallthru), .reconv(reconv),
    .reconv_pc(reconv_pc), .next_pc(next_pc), .active_mask(active_mask),
    .overflow(overflow));

  typedef struct packed {
    logic [1:0]  op;
    logic [31:0] taken, tgt, fall, rpc, emask, epc;
  } vec_t;

  localparam vec_t TBL [11] = '{
    '{2'd1, 32'h0000_0000, 32'h100, 32'h004, 32'h0,   32'hFFFF_FFFF, 32'h004},
    '{2'd1, 32'hFFFF_FFFF, 32'h040, 32'h008, 32'h0,   32'hFFFF_FFFF, 32'h040},
    '{2'd1, 32'h0000_FFFF, 32'h080, 32'h044, 32'h0,   32'hFFFF_0000, 32'h044},
    '{2'd1, 32'h0F00_0000, 32'h0C0, 32'h048, 32'h0,   32'hF0FF_0000, 32'h048},
    '{2'd1, 32'h0000_000F, 32'h200, 32'h04C, 32'h0,   32'hF0FF_0000, 32'h04C},
    '{2'd2, 32'h0,         32'h0,   32'h0,   32'h060, 32'h0F00_0000, 32'h0C0},
    '{2'd2, 32'h0,         32'h0,   32'h0,   32'h064, 32'hFFFF_0000, 32'h064},
    '{2'd2, 32'h0,         32'h0,   32'h0,   32'h070, 32'h0000_FFFF, 32'h080},
    '{2'd0, 32'h0,         32'h0,   32'h0,   32'h0,   32'h0000_FFFF, 32'h080},
    '{2'd2, 32'h0,         32'h0,   32'h0,   32'h090, 32'hFFFF_FFFF, 32'h090},
    '{2'd2, 32'h0,         32'h0,   32'h0,   32'h0A0, 32'hFFFF_FFFF, 32'h090}
  };
  localparam string TAGS [11] = '{"R2", "R3", "R4", "R7", "R2", "R5", "R6", "R7", "R10", "R6", "R9"};

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(input logic [1:0] op, input logic [31:0] tk, tg, fl, rp);
    br_valid = (op == 2'd1); reconv = (op == 2'd2);
    br_taken = tk; br_target = tg; br_fallthru = fl; reconv_pc = rp;
    @(negedge clk);
    br_valid = 1'b0; reconv = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
  endtask

  logic [31:0] m_pc, m_mask;
  logic [31:0] s_tgt [DEPTH], s_pend [DEPTH], s_rest [DEPTH];
  logic        s_ph  [DEPTH];
  int          m_sp;

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    chk("R1 mask", active_mask, 32'hFFFF_FFFF);
    chk("R1 pc", next_pc, 32'h0);
    chk("R1 ovf", {31'b0, overflow}, 32'h0);

    for (int i = 0; i < 11; i++) begin
      step(TBL[i].op, TBL[i].taken, TBL[i].tgt, TBL[i].fall, TBL[i].rpc);
      chk({TAGS[i], " mask"}, active_mask, TBL[i].emask);
      chk({TAGS[i], " pc"}, next_pc, TBL[i].epc);
    end

    // R8: fill the stack with single-thread divergences, then one more
    do_reset();
    for (int i = 0; i < DEPTH; i++)
      step(2'd1, 32'h1 << i, 32'h1000 + 32'(i), 32'h2000 + 32'(i), 32'h0);
    chk("R8 no ovf yet", {31'b0, overflow}, 32'h0);
    step(2'd1, 32'h1 << DEPTH, 32'h3000, 32'h3004, 32'h0);
    chk("R8 ovf set", {31'b0, overflow}, 32'h1);
    chk("R8 mask", active_mask, 32'hFFFF_FFFF << (DEPTH + 1));
    chk("R8 pc", next_pc, 32'h3004);
    step(2'd2, 32'h0, 32'h0, 32'h0, 32'h4000);
    chk("R8 top pend mask", active_mask, 32'h1 << (DEPTH - 1));
    chk("R8 top pend pc", next_pc, 32'h1000 + 32'(DEPTH - 1));
    step(2'd2, 32'h0, 32'h0, 32'h0, 32'h4000);
    chk("R8 top restore", active_mask, 32'hFFFF_FFFF << (DEPTH - 1));
    chk("R8 sticky", {31'b0, overflow}, 32'h1);
    do_reset();
    chk("R1 ovf cleared", {31'b0, overflow}, 32'h0);

    // R7: random nesting against a reference model
    m_pc = 32'h0; m_mask = 32'hFFFF_FFFF; m_sp = 0;
    for (int n = 0; n < 400; n++) begin
      int op;
      logic [31:0] tk, tg, fl, rp, eff;
      op = int'($urandom % 3);
      tk = $urandom; tg = $urandom; fl = $urandom; rp = $urandom;
      if (op == 1 && m_sp == DEPTH) op = 2;
      if (n % 7 == 0) tk = 32'h0;
      if (n % 11 == 0) tk = 32'hFFFF_FFFF;
      eff = tk & m_mask;
      if (op == 1) begin
        if (eff == 0) m_pc = fl;
        else if (eff == m_mask) m_pc = tg;
        else begin
          s_tgt[m_sp] = tg; s_pend[m_sp] = eff; s_rest[m_sp] = m_mask; s_ph[m_sp] = 1'b0;
          m_sp++; m_mask = m_mask & ~tk; m_pc = fl;
        end
      end else if (op == 2 && m_sp > 0) begin
        if (!s_ph[m_sp-1]) begin
          m_mask = s_pend[m_sp-1]; m_pc = s_tgt[m_sp-1]; s_ph[m_sp-1] = 1'b1;
        end else begin
          m_mask = s_rest[m_sp-1]; m_pc = rp; m_sp--;
        end
      end
      step(2'(op), tk, tg, fl, rp);
      chk("R7 model mask", active_mask, m_mask);
      chk("R7 model pc", next_pc, m_pc);
    end
    chk("R7 model ovf", {31'b0, overflow}, 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule